// File: doc/BRIEF.md
# Progressive binarization activation unit

This is a streaming fixed-point unit for networks trained so that their weights and activations drift toward binary values. A scale factor `alpha` steepens the transfer curve as training goes on. In forward mode the unit computes a clipped linear approximation of tanh(alpha*x). The result is linear in the centre and pinned at plus or minus one outside it.

In backward mode the unit passes an incoming gradient scaled by alpha, but only where the forward curve is unsaturated. Because the slope in that region is constant, the forward activations never have to be stored. Two further modes give the final binary value of a parameter, taken from its sign, and a cheap sign of a normalised feature, taken by comparing against a per-channel threshold.

Alpha comes from a small lookup indexed by the training epoch. The lookup rises geometrically from 1 at the first epoch to 1000 at the last. Samples enter and leave on valid/ready streams through a single register stage, and every beat carries its own mode.

Top module: `pbin_act_unit`

## Requirements
- R1: Data is signed fixed point of width W (default 16) with 1.0 encoded as 2^(W-2) (16384). In forward mode (in_mode = 0) the output is floor(x*a/2^F), where a is the alpha code and F = 6 its fraction bits, whenever that value lies strictly between -1.0 and +1.0.
- R2: In forward mode, a scaled value at or above +1.0 yields exactly +1.0, and one at or below -1.0 yields exactly -1.0.
- R3: In backward mode (in_mode = 1) the output is floor(grad*a/2^F) when the scaled input floor(x*a/2^F) lies strictly inside (-1.0, +1.0). Otherwise the output is 0.
- R4: The backward product saturates to the signed W-bit range, -32768 to 32767 by default.
- R5: In sign mode (in_mode = 2) the output is +1.0 for x >= 0, zero included, and -1.0 for negative x.
- R6: In threshold mode (in_mode = 3) the output is +1.0 when x >= thr as signed values, and -1.0 otherwise.
- R7: The alpha code has F = 6 fraction bits. Epoch 0 gives 64 (alpha 1.0), epoch 49 gives 64000 (alpha 1000.0), and each epoch e gives 64*1000^(e/49) within 1%, with no entry smaller than its predecessor.
- R8: An epoch index of 50 or more uses the epoch-49 entry.
- R9: The alpha lookup is registered. After epoch changes, beats accepted at the next rising edge still use the old alpha, and beats accepted from the second rising edge on use the new one.
- R10: A beat accepted at a rising edge (in_valid and in_ready high) appears on out_valid/out_data right after that edge, with one cycle of latency.
- R11: While out_valid is high and out_ready is low, out_data holds, in_ready is low, and no input beat is taken.
- R12: After reset out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| epoch | input | 6 | Training epoch index selecting alpha |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_mode | input | 2 | 0 forward, 1 backward, 2 sign, 3 threshold |
| in_x | input | 16 | Activation or parameter value |
| in_grad | input | 16 | Incoming gradient (backward mode) |
| in_thr | input | 16 | Per-channel threshold (threshold mode) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | 16 | Result |

## Verification
On every cycle the assertions check the following. A stalled output stays put. No output appears without an accepted input. Forward results never leave the +/-1.0 range. Sign and threshold results are exactly +1.0 or -1.0. The registered alpha stays between its first and last table values.

Only the bench scenarios can show the exact numbers. These include the linear values and the exact clip points at alpha 1, about 34 and 1000, the gradient gating on either side of the saturation boundary, and the backward overflow. The scenarios also cover the shape of the whole alpha schedule, the clamp of out-of-range epochs, and the two-edge timing of an epoch change.

// File: rtl/pbin_pkg.sv
package pbin_pkg;
  typedef enum logic [1:0] {
    PB_FWD  = 2'd0,
    PB_BWD  = 2'd1,
    PB_SIGN = 2'd2,
    PB_THR  = 2'd3
  } pb_mode_e;
endpackage

// File: rtl/pbin_alpha_rom.sv
module pbin_alpha_rom #(
  parameter int EPOCHS    = 50,
  parameter int EW        = 6,
  parameter int AW        = 16,
  parameter int FRAC      = 6,
  parameter int RATIO_Q16 = 75458,  // 1000^(1/49) in Q16
  parameter int END_MULT  = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] epoch,
  output logic [AW-1:0] alpha
);
  localparam int SH = FRAC + 16;

  // Geometric schedule, last entry pinned to the end value
  function automatic logic [AW-1:0] entry(input int e);
    longint acc;
    acc = longint'(1) <<< SH;
    for (int i = 0; i < e; i++) acc = (acc * RATIO_Q16 + 32768) >>> 16;
    if (e == EPOCHS - 1) acc = longint'(END_MULT) <<< SH;
    return AW'((acc + 32768) >>> 16);
  endfunction

  localparam logic [AW-1:0] A_FIRST = entry(0);
  localparam logic [AW-1:0] A_LAST  = entry(EPOCHS - 1);

  logic [AW-1:0] table_w [EPOCHS];
  for (genvar e = 0; e < EPOCHS; e++) begin : g_tab
    assign table_w[e] = entry(e);
  end

  logic [EW-1:0] idx;
  always_comb begin
    if (32'(epoch) >= EPOCHS) idx = EW'(EPOCHS - 1);
    else                      idx = epoch;
  end

  always_ff @(posedge clk) begin
    if (rst) alpha <= A_FIRST;
    else     alpha <= table_w[idx];
  end

  // R7
  alpha_range_chk: assert property (@(posedge clk) disable iff (rst)
    (alpha >= A_FIRST) && (alpha <= A_LAST));
endmodule

// File: rtl/pbin_datapath.sv
module pbin_datapath
  import pbin_pkg::*;
#(
  parameter int W    = 16,
  parameter int AW   = 16,
  parameter int FRAC = 6
) (
  input  pb_mode_e       mode,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   grad,
  input  logic [W-1:0]   thr,
  input  logic [AW-1:0]  alpha,
  output logic [W-1:0]   result
);
  localparam int PW = W + AW + 1;
  localparam logic signed [PW-1:0] ONE_P = PW'(longint'(1) <<< (W - 2));
  localparam logic signed [PW-1:0] MAX_P = PW'((longint'(1) <<< (W - 1)) - 1);
  localparam logic signed [PW-1:0] MIN_P = -PW'(longint'(1) <<< (W - 1));
  localparam logic [W-1:0] ONE_W  = W'(longint'(1) <<< (W - 2));
  localparam logic [W-1:0] MONE_W = -ONE_W;

  logic signed [PW-1:0] xe, ge, ae, fsc, gsc;
  logic                 in_lin;
  logic [W-1:0]         fwd_v, bwd_v;

  always_comb begin
    xe  = PW'($signed(x));
    ge  = PW'($signed(grad));
    ae  = PW'({1'b0, alpha});
    fsc = (xe * ae) >>> FRAC;
    gsc = (ge * ae) >>> FRAC;
    in_lin = (fsc < ONE_P) && (fsc > -ONE_P);

    if (fsc >= ONE_P)       fwd_v = ONE_W;
    else if (fsc <= -ONE_P) fwd_v = MONE_W;
    else                    fwd_v = W'(fsc);

    if (!in_lin)            bwd_v = '0;
    else if (gsc > MAX_P)   bwd_v = W'(MAX_P);
    else if (gsc < MIN_P)   bwd_v = W'(MIN_P);
    else                    bwd_v = W'(gsc);

    unique case (mode)
      PB_FWD:  result = fwd_v;
      PB_BWD:  result = bwd_v;
      PB_SIGN: result = x[W-1] ? MONE_W : ONE_W;
      default: result = ($signed(x) >= $signed(thr)) ? ONE_W : MONE_W;
    endcase
  end
endmodule

// File: rtl/pbin_act_unit.sv
module pbin_act_unit
  import pbin_pkg::*;
#(
  parameter int W         = 16,
  parameter int AW        = 16,
  parameter int FRAC      = 6,
  parameter int EPOCHS    = 50,
  parameter int RATIO_Q16 = 75458,
  parameter int END_MULT  = 1000,
  localparam int EW       = $clog2(EPOCHS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] epoch,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic [W-1:0]  in_x,
  input  logic [W-1:0]  in_grad,
  input  logic [W-1:0]  in_thr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data
);
  localparam logic signed [W-1:0] ONE_S = W'(longint'(1) <<< (W - 2));

  logic [AW-1:0] alpha;
  logic [W-1:0]  res_c;
  pb_mode_e      mode_c, mode_q;

  assign mode_c = pb_mode_e'(in_mode);

  pbin_alpha_rom #(
    .EPOCHS(EPOCHS), .EW(EW), .AW(AW), .FRAC(FRAC),
    .RATIO_Q16(RATIO_Q16), .END_MULT(END_MULT)
  ) u_rom (
    .clk(clk), .rst(rst), .epoch(epoch), .alpha(alpha)
  );

  pbin_datapath #(.W(W), .AW(AW), .FRAC(FRAC)) u_dp (
    .mode(mode_c), .x(in_x), .grad(in_grad), .thr(in_thr),
    .alpha(alpha), .result(res_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      mode_q    <= PB_FWD;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= res_c;
      mode_q    <= mode_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid));

  // R2
  fwd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == PB_FWD) |->
      ($signed(out_data) <= ONE_S && $signed(out_data) >= -ONE_S));

  // R5 R6
  binary_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (mode_q == PB_SIGN || mode_q == PB_THR)) |->
      ($signed(out_data) == ONE_S || $signed(out_data) == -ONE_S));
endmodule

// File: tb/pbin_act_unit_tb.sv
module pbin_act_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  epoch = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [15:0] in_x = '0, in_grad = '0, in_thr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int     checks = 0;
  int     fails  = 0;
  longint res;
  longint acode;

  always #2 clk = ~clk;

  pbin_act_unit u_dut (
    .clk(clk), .rst(rst), .epoch(epoch), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_x(in_x), .in_grad(in_grad), .in_thr(in_thr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic longint rfwd(longint x, longint a);
    longint s = (x * a) >>> 6;
    if (s >= 16384) return 16384;
    if (s <= -16384) return -16384;
    return s;
  endfunction

  function automatic longint rbwd(longint x, longint g, longint a);
    longint s = (x * a) >>> 6;
    longint p = (g * a) >>> 6;
    if (s >= 16384 || s <= -16384) return 0;
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return p;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(int mode, longint x, longint g, longint t);
    @(negedge clk);
    in_mode = 2'(mode); in_x = 16'(x); in_grad = 16'(g); in_thr = 16'(t);
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 out_valid after accept", longint'(out_valid), 1);
    res = longint'($signed(out_data));
  endtask

  task automatic set_epoch(int e);
    @(negedge clk);
    epoch = 6'(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 out_valid in reset", longint'(out_valid), 0);
    check("R12 in_ready in reset", longint'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R12 out_valid after reset", longint'(out_valid), 0);
  endtask

  task automatic t_fwd_unit();
    set_epoch(0);
    send(0, 8192, 0, 0);    check("R1 fwd 0.5 a=1", res, 8192);
    send(0, -3, 0, 0);      check("R1 fwd -3 a=1", res, -3);
    send(0, 16383, 0, 0);   check("R1 fwd just inside", res, 16383);
    send(0, 16384, 0, 0);   check("R2 fwd at +1.0", res, 16384);
    send(0, 20000, 0, 0);   check("R2 fwd above +1.0", res, 16384);
    send(0, -16384, 0, 0);  check("R2 fwd at -1.0", res, -16384);
    send(0, -20000, 0, 0);  check("R2 fwd below -1.0", res, -16384);
  endtask

  task automatic t_bwd_unit();
    set_epoch(0);
    send(1, 16383, 1000, 0);  check("R3 bwd inside +", res, 1000);
    send(1, 16384, 1000, 0);  check("R3 bwd at +boundary", res, 0);
    send(1, -16383, -700, 0); check("R3 bwd inside -", res, -700);
    send(1, -16384, 1000, 0); check("R3 bwd at -boundary", res, 0);
  endtask

  task automatic t_alpha_max();
    set_epoch(49);
    send(0, 16, 0, 0);    check("R1 fwd a=1000 linear", res, 16000);
    send(0, 17, 0, 0);    check("R2 fwd a=1000 clip", res, 16384);
    send(0, -17, 0, 0);   check("R2 fwd a=1000 clip neg", res, -16384);
    send(1, 16, 10, 0);   check("R3 bwd a=1000", res, 10000);
    send(1, 17, 10, 0);   check("R3 bwd a=1000 gated", res, 0);
    send(1, 16, 100, 0);  check("R4 bwd sat high", res, 32767);
    send(1, -16, -100, 0);check("R4 bwd sat low", res, -32768);
  endtask

  task automatic t_alpha_mid();
    real    expa;
    longint xb;
    set_epoch(25);
    send(1, 0, 64, 0);
    acode = res;
    expa = 64.0 * $pow(1000.0, 25.0 / 49.0);
    check("R7 alpha mid within 1%", longint'((acode > expa * 0.99 && acode < expa * 1.01) ? 1 : 0), 1);
    xb = (16384 * 64 + acode - 1) / acode;
    send(0, 200, 0, 0);     check("R1 fwd a~34", res, rfwd(200, acode));
    send(0, -483, 0, 0);    check("R1 fwd a~34 neg", res, rfwd(-483, acode));
    send(0, xb, 0, 0);      check("R2 fwd a~34 boundary", res, 16384);
    send(0, xb - 1, 0, 0);  check("R1 fwd a~34 below boundary", res, rfwd(xb - 1, acode));
    send(1, xb, 300, 0);    check("R3 bwd a~34 boundary gated", res, 0);
    send(1, xb - 1, 300, 0);check("R3 bwd a~34 inside", res, rbwd(xb - 1, 300, acode));
  endtask

  task automatic t_sign();
    send(2, 0, 0, 0);      check("R5 sign zero", res, 16384);
    send(2, -1, 0, 0);     check("R5 sign -1", res, -16384);
    send(2, 12345, 0, 0);  check("R5 sign pos", res, 16384);
    send(2, -32768, 0, 0); check("R5 sign min", res, -16384);
  endtask

  task automatic t_thresh();
    send(3, 100, 0, 100);   check("R6 thr equal", res, 16384);
    send(3, 99, 0, 100);    check("R6 thr below", res, -16384);
    send(3, -50, 0, -80);   check("R6 thr neg above", res, 16384);
  endtask

  task automatic t_sweep();
    longint prev = 0;
    real    expv;
    for (int e = 0; e < 50; e++) begin
      set_epoch(e);
      send(1, 0, 32, 0);
      expv = 32.0 * $pow(1000.0, real'(e) / 49.0);
      if (e == 0)  check("R7 alpha epoch0", res, 32);
      if (e == 49) check("R7 alpha epoch49", res, 32000);
      check($sformatf("R7 alpha epoch %0d within 1%%", e),
            longint'((res >= expv * 0.99 - 1.0 && res <= expv * 1.01 + 1.0) ? 1 : 0), 1);
      check($sformatf("R7 alpha epoch %0d nondecreasing", e), longint'(res >= prev ? 1 : 0), 1);
      prev = res;
    end
  endtask

  task automatic t_clamp();
    set_epoch(50);
    send(1, 0, 32, 0); check("R8 epoch 50 clamp", res, 32000);
    set_epoch(63);
    send(1, 0, 32, 0); check("R8 epoch 63 clamp", res, 32000);
  endtask

  task automatic t_epoch_latency();
    set_epoch(0);
    @(negedge clk);
    epoch = 6'd49;
    in_mode = 2'd1; in_x = '0; in_grad = 16'd32; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 first beat old alpha", longint'($signed(out_data)), 32);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second beat new alpha", longint'($signed(out_data)), 32000);
  endtask

  task automatic t_stall();
    set_epoch(0);
    @(negedge clk);
    in_mode = 2'd0; in_x = 16'd1000; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_x = 16'd2000;
    check("R11 stalled valid", longint'(out_valid), 1);
    check("R11 stalled in_ready low", longint'(in_ready), 0);
    repeat (3) @(negedge clk);
    check("R11 stalled data held", longint'($signed(out_data)), 1000);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next beat after release", longint'($signed(out_data)), 2000);
    @(posedge clk);
    @(negedge clk);
    check("R10 valid drops when drained", longint'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_fwd_unit();
    t_bwd_unit();
    t_alpha_max();
    t_alpha_mid();
    t_sign();
    t_thresh();
    t_sweep();
    t_clamp();
    t_epoch_latency();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule